// File: doc/BRIEF.md
# Windowed Line Signal Quality Monitor

This block judges the health of a received line from a per-clock "bad symbol" flag that the line decoder produces. It does not react to single errors. Time is cut into fixed observation windows of `WIN_CYCLES` clocks, 1024 by default. At the close of each window a small saturating score moves one step. It moves up when the window held at least one qualified bad symbol, and down when the window was clean.

The score runs from 0 to `SCORE_MAX`, 7 by default. The status output flags the line as bad as soon as the score reaches the top. It flags the line as good again only once the score has worked its way back down to 0. A noisy line therefore needs at least seven consecutive dirty windows to be declared bad, and a bad line needs seven clean windows to recover. The current score is also brought out for debug.

A bad-symbol flag counts only in a cycle where the symbol-valid strobe is high. Any qualified bad symbol sets a sticky per-window error flag. The score update at the window boundary reads that flag, and the flag is cleared on the same edge.

Top module: `line_quality_mon`

## Requirements
- R1: A synchronous active-high reset sets the score to 0 and the status to good (`sig_good`=1), and restarts the window timer. It also drops any bad symbol seen before reset, so a clean window after reset leaves the score at 0.
- R2: A window closes on the 1024th rising edge with reset low, counting from the end of reset, and on every 1024th edge after that. The score and status change only on those closing edges.
- R3: At a window close, if the window held at least one cycle with `sym_valid`=1 and `sym_bad`=1 (the closing cycle included), the score rises by one.
- R4: At a window close, if the window held no such cycle, the score falls by one.
- R5: The score never exceeds 7. A dirty window at 7 leaves it at 7.
- R6: The score never goes below 0. A clean window at 0 leaves it at 0.
- R7: `sig_good` goes to 0 on the same edge that the score reaches 7. Starting from 0, this takes seven consecutive dirty windows.
- R8: Once `sig_good` is 0 it stays 0 while the score is 1 to 6. It returns to 1 on the same edge that the score reaches 0.
- R9: `sym_bad`=1 in a cycle with `sym_valid`=0 has no effect. A window containing only such cycles counts as clean.
- R10: The error flag is cleared at each window close, so a bad symbol affects only the window it falls in. The next window, if clean, lowers the score.
- R11: While the score climbs from 0 through 1 to 6, `sig_good` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | High in cycles that carry a decoded symbol |
| sym_bad | input | 1 | Decoder flag for an invalid symbol, qualified by `sym_valid` |
| sig_good | output | 1 | Registered status: 1 good, 0 bad |
| score | output | 3 | Current quality score, 0 (clean) to 7 (bad) |

## Verification
The hardest situations to reach are the ones tied to the window edges. A bad symbol in the very last cycle of a window must count toward that window and not leak into the next. A reset partway through a window must discard both the partial timer count and a bad symbol already latched. The stimulus places bad pulses at the first cycle, the last cycle and interior positions of successive windows. It also asserts reset about halfway into a window that already holds a bad pulse, then checks that the following full windows line up with the restarted timer. A behavioural model compares the score and status on every clock, so an update that lands one edge early or late is caught.

// File: rtl/lqm_pkg.sv
package lqm_pkg;

  // Direction of the score move decided at a window close.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Status encoding used on the sig_good output.
  typedef enum logic {
    LINE_BAD  = 1'b0,
    LINE_GOOD = 1'b1
  } line_state_e;

endpackage

// File: rtl/lqm_window_timer.sv
module lqm_window_timer #(
  parameter int WIN_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic win_end
);

  localparam int TW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);
  localparam bit IS_POW2 = ((WIN_CYCLES & (WIN_CYCLES - 1)) == 0);

  logic [TW-1:0] cnt_q;

  assign win_end = (cnt_q == LAST);

  generate
    if (IS_POW2) begin : g_pow2
      // Power-of-two window: the counter wraps on its own.
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (win_end) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  AST_TIMER_WRAP: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/lqm_err_latch.sv
module lqm_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic sym_valid,
  input  logic sym_bad,
  input  logic win_end,
  output logic win_dirty
);

  logic flag_q;
  logic hit;

  // Only qualified symbols count.
  assign hit       = sym_valid & sym_bad;
  assign win_dirty = flag_q | hit;

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (win_end) flag_q <= 1'b0;
    else              flag_q <= win_dirty;
  end

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    win_end |=> !flag_q); // R10

  AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !sym_valid) |=> !flag_q); // R9

endmodule

// File: rtl/lqm_score.sv
module lqm_score
  import lqm_pkg::*;
#(
  parameter int SCORE_MAX = 7,
  localparam int SW = $clog2(SCORE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_end,
  input  logic          win_dirty,
  output logic [SW-1:0] score_q,
  output logic          good_q
);

  localparam logic [SW-1:0] TOP = SW'(SCORE_MAX);

  step_e         step;
  logic [SW-1:0] score_d;
  logic          good_d;

  always_comb begin
    step = STEP_HOLD;
    if (win_end) begin
      if (win_dirty && score_q != TOP)       step = STEP_UP;
      else if (!win_dirty && score_q != '0)  step = STEP_DOWN;
    end
  end

  always_comb begin
    unique case (step)
      STEP_UP:   score_d = score_q + 1'b1;
      STEP_DOWN: score_d = score_q - 1'b1;
      default:   score_d = score_q;
    endcase
  end

  // Hysteresis: flip only at the two ends of the range.
  always_comb begin
    good_d = good_q;
    if (score_d == TOP)     good_d = LINE_BAD;
    else if (score_d == '0) good_d = LINE_GOOD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      score_q <= '0;
      good_q  <= LINE_GOOD;
    end else begin
      score_q <= score_d;
      good_q  <= good_d;
    end
  end

  AST_SCORE_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(score_q) <= SCORE_MAX); // R5

  AST_BAD_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (score_q == TOP) |-> !good_q); // R7

  AST_GOOD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (score_q == '0) |-> good_q); // R8

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(score_q) - int'($past(score_q)) <= 1 &&
              int'($past(score_q)) - int'(score_q) <= 1)); // R3

  AST_MID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (score_q != '0 && score_q != TOP) |=>
      ((score_q == '0 || score_q == TOP) || good_q == $past(good_q))); // R11

endmodule

// File: rtl/line_quality_mon.sv
module line_quality_mon
  import lqm_pkg::*;
#(
  parameter int WIN_CYCLES = 1024,
  parameter int SCORE_MAX  = 7,
  localparam int SW = $clog2(SCORE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sym_valid,
  input  logic          sym_bad,
  output logic          sig_good,
  output logic [SW-1:0] score
);

  logic win_end;
  logic win_dirty;

  lqm_window_timer #(
    .WIN_CYCLES (WIN_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .win_end (win_end)
  );

  lqm_err_latch u_err (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_bad   (sym_bad),
    .win_end   (win_end),
    .win_dirty (win_dirty)
  );

  lqm_score #(
    .SCORE_MAX (SCORE_MAX)
  ) u_score (
    .clk       (clk),
    .rst       (rst),
    .win_end   (win_end),
    .win_dirty (win_dirty),
    .score_q   (score),
    .good_q    (sig_good)
  );

  AST_WIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> ($stable(score) && $stable(sig_good))); // R2

  AST_INC: assert property (@(posedge clk) disable iff (rst)
    (win_end && win_dirty && int'(score) < SCORE_MAX) |=>
      (int'(score) == int'($past(score)) + 1)); // R3

  AST_DEC: assert property (@(posedge clk) disable iff (rst)
    (win_end && !win_dirty && score != '0) |=>
      (int'(score) + 1 == int'($past(score)))); // R4

  AST_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (win_end && !win_dirty && score == '0) |=> (score == '0)); // R6

endmodule

// File: tb/line_quality_mon_tb.sv
module line_quality_mon_tb;

  localparam int WIN = 1024;
  localparam int TOP = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_valid = 1'b0;
  logic       sym_bad = 1'b0;
  logic       sig_good;
  logic [2:0] score;

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // Behavioural reference state
  int  m_cnt = 0;
  bit  m_flag = 1'b0;
  int  m_score = 0;
  bit  m_good = 1'b1;

  always #2.5 clk = ~clk;

  line_quality_mon u_dut (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_bad   (sym_bad),
    .sig_good  (sig_good),
    .score     (score)
  );

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cnt = 0; m_flag = 1'b0; m_score = 0; m_good = 1'b1;
    end else begin
      if (sym_valid && sym_bad) m_flag = 1'b1;
      if (m_cnt == WIN - 1) begin
        if (m_flag) m_score = (m_score < TOP) ? m_score + 1 : TOP;
        else        m_score = (m_score > 0) ? m_score - 1 : 0;
        if (m_score == TOP)    m_good = 1'b0;
        else if (m_score == 0) m_good = 1'b1;
        m_flag = 1'b0;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  // Per-clock comparison against the model (R2 timing, R3/R4 steps)
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (int'(score) != m_score || sig_good !== m_good) begin
        errors++;
        $display("FAIL R2 per-cycle: actual score=%0d good=%0b expected score=%0d good=%0b",
                 score, sig_good, m_score, m_good);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sym_valid = 1'b0; sym_bad = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // One full window; bad pulse at cycle pos (-1: none). junk=1 drives
  // sym_bad high with sym_valid low for the whole window.
  task automatic run_window(input int pos, input bit junk);
    int prev;
    prev = int'(score);
    for (int i = 0; i < WIN; i++) begin
      if (junk) begin
        sym_valid = 1'b0; sym_bad = 1'b1;
      end else begin
        sym_valid = (i == pos) || (i % 5 != 0);
        sym_bad   = (i == pos);
      end
      @(negedge clk);
      if (i == WIN - 2) check("R2 score held inside window", int'(score), prev);
    end
    sym_valid = 1'b0; sym_bad = 1'b0;
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pos_list[7] = '{0, WIN - 1, 511, 5, 100, 900, 300};
    do_reset();
    check("R1 reset score", int'(score), 0);
    check("R1 reset good", int'(sig_good), 1);

    // Seven dirty windows: climb to the top
    for (int k = 0; k < 7; k++) begin
      run_window(pos_list[k], 1'b0);
      check("R3 score rises", int'(score), k + 1);
      if (k < 6) check("R11 good while climbing", int'(sig_good), 1);
      else       check("R7 bad at seven", int'(sig_good), 0);
    end

    // Saturation at the top
    for (int k = 0; k < 2; k++) begin
      run_window(700, 1'b0);
      check("R5 score held at 7", int'(score), 7);
      check("R5 still bad", int'(sig_good), 0);
    end

    // Unqualified bad flags count as clean windows
    for (int k = 0; k < 6; k++) begin
      run_window(-1, 1'b1);
      check("R9 R4 score falls", int'(score), 6 - k);
      check("R8 stays bad above zero", int'(sig_good), 0);
    end
    run_window(-1, 1'b0);
    check("R4 score reaches zero", int'(score), 0);
    check("R8 good again at zero", int'(sig_good), 1);

    // Saturation at the floor
    for (int k = 0; k < 2; k++) begin
      run_window(-1, 1'b0);
      check("R6 score held at 0", int'(score), 0);
    end

    // A bad pulse on the last cycle belongs only to its own window
    run_window(WIN - 1, 1'b0);
    check("R3 last-cycle pulse counts", int'(score), 1);
    run_window(-1, 1'b0);
    check("R10 flag cleared at boundary", int'(score), 0);

    // Reset in mid-window with a latched bad symbol
    run_window(3, 1'b0);
    check("R3 pre-reset window", int'(score), 1);
    for (int i = 0; i < 500; i++) begin
      sym_valid = (i == 10); sym_bad = (i == 10);
      @(negedge clk);
    end
    do_reset();
    check("R1 mid-run reset score", int'(score), 0);
    check("R1 mid-run reset good", int'(sig_good), 1);
    run_window(-1, 1'b0);
    check("R1 latched error discarded", int'(score), 0);
    run_window(WIN - 1, 1'b0);
    check("R2 window realigned after reset", int'(score), 1);
    check("R11 good at one", int'(sig_good), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule